// File: doc/BRIEF.md
# Decimal Quotient Rounding and Exception Stage

This block is the last stage of a decimal floating-point divider. The digit recurrence hands it a truncated quotient, that quotient already incremented by one unit in the last place, one rounding digit, a sticky bit and the sign of the result. The block picks one of the two quotients according to the active rounding mode. It needs no adder, because a division quotient cannot carry out of its top digit when it rounds.

In the same cycle the block combines the class flags of both operands with the overflow and underflow indications from the exponent logic. From these it derives six exception flags. The selected significand and the flags are captured in one output register stage, qualified by a valid strobe.

The block also has a small combinational operand path that sits ahead of the divider. When either operand is a NaN, this path sends the NaN's significand forward as the dividend and replaces the divisor with one. The payload then comes out of the divider unchanged.

Top module: `dfr_div_round`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_sig` and all six flags are 0 until the first accepted input.
- R2: An input accepted with `in_valid` high appears on the outputs one clock later, with `out_valid` high. When `in_valid` is low, `out_valid` goes low and `out_sig` and all flags keep their values.
- R3: With `in_mode` = 0 (nearest, ties to even), the incremented quotient is chosen when the rounding digit is 6 to 9, or when it is 5 and either the sticky bit is set or the quotient's last digit is odd. Odd means bit 0 of `in_quot` is 1.
- R4: With `in_mode` = 1 (nearest, ties away), the incremented quotient is chosen when the rounding digit is 5 or more.
- R5: With `in_mode` = 2 (toward plus infinity), the incremented quotient is chosen when `in_sign` = 0 and the rounding digit or the sticky bit is nonzero. With `in_mode` = 3 (toward minus infinity), the same rule applies with `in_sign` = 1.
- R6: With `in_mode` = 4 (toward zero), and with the unused codes 5 to 7, the truncated quotient is always chosen.
- R7: `f_inexact` is 1 exactly when the rounding digit is nonzero or the sticky bit is set.
- R8: `f_divzero` is 1 when the divisor is zero and the dividend is finite and nonzero.
- R9: `f_invalid` is 1 when both operands are zero, when both are infinite, or when either operand is a quiet or signalling NaN.
- R10: `f_infinity` is 1 on overflow, on division by zero, or when the dividend is infinite and the divisor is finite. A zero divisor counts as finite.
- R11: `f_overflow` and `f_underflow` register `in_ovf` and `in_unf` unchanged.
- R12: If an operand is a NaN, `steer_dvs` is the value one (digit 0 = 1, all other digits 0), and `steer_dvd` carries that NaN operand's significand. With no NaN, both significands pass through unchanged. This path is combinational.
- R13: With the default `NAN_PICK` = 0, the dividend's significand is forwarded when both operands are NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input qualifier |
| in_sign | input | 1 | Sign of the quotient (1 = negative) |
| in_rdig | input | 4 | Rounding digit, BCD |
| in_sticky | input | 1 | Nonzero remainder beyond the rounding digit |
| in_quot | input | 4*NDIG | Truncated quotient significand, BCD |
| in_quot_inc | input | 4*NDIG | Quotient plus one unit in the last place, BCD |
| in_mode | input | 3 | Rounding mode code |
| dvd_zero | input | 1 | Dividend is zero |
| dvd_inf | input | 1 | Dividend is infinite |
| dvd_qnan | input | 1 | Dividend is a quiet NaN |
| dvd_snan | input | 1 | Dividend is a signalling NaN |
| dvs_zero | input | 1 | Divisor is zero |
| dvs_inf | input | 1 | Divisor is infinite |
| dvs_qnan | input | 1 | Divisor is a quiet NaN |
| dvs_snan | input | 1 | Divisor is a signalling NaN |
| in_ovf | input | 1 | Overflow from exponent logic |
| in_unf | input | 1 | Underflow from exponent logic |
| dvd_sig | input | 4*NDIG | Raw dividend significand |
| dvs_sig | input | 4*NDIG | Raw divisor significand |
| steer_dvd | output | 4*NDIG | Dividend to be used by the divider |
| steer_dvs | output | 4*NDIG | Divisor to be used by the divider |
| out_valid | output | 1 | Result qualifier |
| out_sig | output | 4*NDIG | Rounded significand |
| f_invalid | output | 1 | Invalid operation |
| f_divzero | output | 1 | Division by zero |
| f_overflow | output | 1 | Overflow |
| f_underflow | output | 1 | Underflow |
| f_inexact | output | 1 | Inexact result |
| f_infinity | output | 1 | Result is infinite |

## Verification
The bench builds the block with `NDIG` = 4 and the default `NAN_PICK` = 0. With four digits, the truncated quotient 1234 or 1235 and its increment can be told apart at a glance. Bit 0 of the last digit is set directly, which gives full control over the ties-to-even case. The default NaN ordering lets one vector with both operands NaN confirm that the dividend wins. The mode and digit cases around 5 are walked as a table. The exception combinations, the output hold and the NaN steering are exercised as directed cases.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

   typedef enum logic [2:0] {
      RM_TIES_EVEN = 3'd0,
      RM_TIES_AWAY = 3'd1,
      RM_TO_POS    = 3'd2,
      RM_TO_NEG    = 3'd3,
      RM_TO_ZERO   = 3'd4
   } rmode_e;

   typedef struct packed {
      logic zero;
      logic inf;
      logic qnan;
      logic snan;
   } opclass_t;

   typedef struct packed {
      logic invalid;
      logic divzero;
      logic overflow;
      logic underflow;
      logic inexact;
      logic infinity;
   } exc_t;

   function automatic logic is_nan(opclass_t c);
      return c.qnan | c.snan;
   endfunction

   function automatic logic is_finite(opclass_t c);
      return ~(c.inf | c.qnan | c.snan);
   endfunction

endpackage

// File: rtl/dfr_round_decide.sv
module dfr_round_decide
   import dfr_pkg::*;
#(
   parameter int NDIG = 16,
   localparam int SW = 4 * NDIG
) (
   input  logic [2:0]    mode,
   input  logic          sign,
   input  logic [3:0]    rdig,
   input  logic          sticky,
   input  logic [SW-1:0] quot,
   input  logic [SW-1:0] quot_inc,
   output logic          inexact,
   output logic [SW-1:0] sel_sig
);

   logic rnz, above_half, at_half, lsd_odd, bump;

   assign rnz        = (rdig != 4'd0);
   assign above_half = (rdig > 4'd5);
   assign at_half    = (rdig == 4'd5);
   assign lsd_odd    = quot[0];
   assign inexact    = rnz | sticky;

   always_comb begin
      unique case (rmode_e'(mode))
         RM_TIES_EVEN: bump = above_half | (at_half & (sticky | lsd_odd));
         RM_TIES_AWAY: bump = above_half | at_half;
         RM_TO_POS:    bump = ~sign & inexact;
         RM_TO_NEG:    bump = sign & inexact;
         default:      bump = 1'b0;
      endcase
   end

   for (genvar d = 0; d < NDIG; d++) begin : g_digit
      assign sel_sig[4*d +: 4] = bump ? quot_inc[4*d +: 4] : quot[4*d +: 4];
   end

endmodule

// File: rtl/dfr_exc_flags.sv
module dfr_exc_flags
   import dfr_pkg::*;
(
   input  opclass_t a,
   input  opclass_t b,
   input  logic     ovf,
   input  logic     unf,
   input  logic     inexact,
   output exc_t     flags
);

   logic any_nan, dz;

   assign any_nan = is_nan(a) | is_nan(b);
   assign dz      = b.zero & is_finite(a) & ~a.zero;

   always_comb begin
      flags.invalid   = (a.zero & b.zero) | (a.inf & b.inf) | any_nan;
      flags.divzero   = dz;
      flags.overflow  = ovf;
      flags.underflow = unf;
      flags.inexact   = inexact;
      flags.infinity  = ovf | dz | (a.inf & is_finite(b));
   end

endmodule

// File: rtl/dfr_nan_steer.sv
module dfr_nan_steer
   import dfr_pkg::*;
#(
   parameter int NDIG     = 16,
   parameter int NAN_PICK = 0,
   localparam int SW = 4 * NDIG
) (
   input  opclass_t      a,
   input  opclass_t      b,
   input  logic [SW-1:0] a_sig,
   input  logic [SW-1:0] b_sig,
   output logic [SW-1:0] fwd_a,
   output logic [SW-1:0] fwd_b
);

   localparam logic [SW-1:0] UNITY = SW'(1);

   logic any_nan, take_b;

   assign any_nan = is_nan(a) | is_nan(b);

   if (NAN_PICK == 0) begin : g_dividend_first
      assign take_b = is_nan(b) & ~is_nan(a);
   end else begin : g_signalling_first
      assign take_b = (b.snan & ~a.snan) | (is_nan(b) & ~is_nan(a));
   end

   assign fwd_a = take_b ? b_sig : a_sig;
   assign fwd_b = any_nan ? UNITY : b_sig;

endmodule

// File: rtl/dfr_div_round.sv
module dfr_div_round
   import dfr_pkg::*;
#(
   parameter int NDIG     = 16,
   parameter int NAN_PICK = 0,
   localparam int SW = 4 * NDIG
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sign,
   input  logic [3:0]    in_rdig,
   input  logic          in_sticky,
   input  logic [SW-1:0] in_quot,
   input  logic [SW-1:0] in_quot_inc,
   input  logic [2:0]    in_mode,
   input  logic          dvd_zero,
   input  logic          dvd_inf,
   input  logic          dvd_qnan,
   input  logic          dvd_snan,
   input  logic          dvs_zero,
   input  logic          dvs_inf,
   input  logic          dvs_qnan,
   input  logic          dvs_snan,
   input  logic          in_ovf,
   input  logic          in_unf,
   input  logic [SW-1:0] dvd_sig,
   input  logic [SW-1:0] dvs_sig,
   output logic [SW-1:0] steer_dvd,
   output logic [SW-1:0] steer_dvs,
   output logic          out_valid,
   output logic [SW-1:0] out_sig,
   output logic          f_invalid,
   output logic          f_divzero,
   output logic          f_overflow,
   output logic          f_underflow,
   output logic          f_inexact,
   output logic          f_infinity
);

   if (NDIG < 1 || NDIG > 34) begin : g_bad_ndig
      $error("dfr_div_round: NDIG must lie in 1..34");
   end
   if (NAN_PICK != 0 && NAN_PICK != 1) begin : g_bad_pick
      $error("dfr_div_round: NAN_PICK must be 0 or 1");
   end

   opclass_t cls_a, cls_b;
   assign cls_a = '{zero: dvd_zero, inf: dvd_inf, qnan: dvd_qnan, snan: dvd_snan};
   assign cls_b = '{zero: dvs_zero, inf: dvs_inf, qnan: dvs_qnan, snan: dvs_snan};

   logic          inexact_c;
   logic [SW-1:0] sig_c;
   exc_t          flags_c, flags_q;

   dfr_round_decide #(.NDIG(NDIG)) i_round (
      .mode     (in_mode),
      .sign     (in_sign),
      .rdig     (in_rdig),
      .sticky   (in_sticky),
      .quot     (in_quot),
      .quot_inc (in_quot_inc),
      .inexact  (inexact_c),
      .sel_sig  (sig_c)
   );

   dfr_exc_flags i_exc (
      .a       (cls_a),
      .b       (cls_b),
      .ovf     (in_ovf),
      .unf     (in_unf),
      .inexact (inexact_c),
      .flags   (flags_c)
   );

   dfr_nan_steer #(.NDIG(NDIG), .NAN_PICK(NAN_PICK)) i_steer (
      .a     (cls_a),
      .b     (cls_b),
      .a_sig (dvd_sig),
      .b_sig (dvs_sig),
      .fwd_a (steer_dvd),
      .fwd_b (steer_dvs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sig   <= '0;
         flags_q   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sig <= sig_c;
            flags_q <= flags_c;
         end
      end
   end

   assign f_invalid   = flags_q.invalid;
   assign f_divzero   = flags_q.divzero;
   assign f_overflow  = flags_q.overflow;
   assign f_underflow = flags_q.underflow;
   assign f_inexact   = flags_q.inexact;
   assign f_infinity  = flags_q.infinity;

endmodule

// File: rtl/dfr_div_round_chk.sv
module dfr_div_round_chk #(
   parameter int NDIG = 16,
   localparam int SW = 4 * NDIG
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [3:0]    in_rdig,
   input logic          in_sticky,
   input logic [SW-1:0] in_quot,
   input logic [SW-1:0] in_quot_inc,
   input logic [2:0]    in_mode,
   input logic          dvd_zero,
   input logic          dvd_inf,
   input logic          dvd_qnan,
   input logic          dvd_snan,
   input logic          dvs_zero,
   input logic          dvs_qnan,
   input logic          dvs_snan,
   input logic [SW-1:0] steer_dvs,
   input logic          out_valid,
   input logic [SW-1:0] out_sig,
   input logic          f_invalid,
   input logic          f_divzero,
   input logic          f_inexact
);

   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_sig) && $stable(f_invalid)));

   assert_above_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 3'd0 && in_rdig > 4'd5 && in_rdig <= 4'd9)
      |=> out_sig == $past(in_quot_inc));

   assert_truncate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode >= 3'd4) |=> out_sig == $past(in_quot));

   assert_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_rdig == 4'd0 && !in_sticky) |=> !f_inexact);

   assert_divzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dvs_zero && !dvd_zero && !dvd_inf && !dvd_qnan && !dvd_snan)
      |=> f_divzero);

   assert_nan_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (dvd_qnan || dvd_snan || dvs_qnan || dvs_snan)) |=> f_invalid);

   assert_unity_divisor_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (dvd_qnan || dvd_snan || dvs_qnan || dvs_snan) |-> steer_dvs == SW'(1));

endmodule

bind dfr_div_round dfr_div_round_chk #(.NDIG(NDIG)) i_chk (.*);

// File: tb/test_dfr_div_round.sv
`timescale 1ns/1ps
module test_dfr_div_round;

   localparam int NDIG = 4;
   localparam int SW   = 4 * NDIG;
   localparam int NV   = 20;

   // fields: mode[10:8] sign[7] rdig[6:3] sticky[2] lsd_odd[1] expect_up[0]
   localparam logic [10:0] VEC [0:NV-1] = '{
      {3'd0, 1'b0, 4'd6, 1'b0, 1'b0, 1'b1},   // R3 above half
      {3'd0, 1'b0, 4'd5, 1'b0, 1'b0, 1'b0},   // R3 tie, even
      {3'd0, 1'b1, 4'd5, 1'b0, 1'b1, 1'b1},   // R3 tie, odd
      {3'd0, 1'b0, 4'd5, 1'b1, 1'b0, 1'b1},   // R3 half plus sticky
      {3'd0, 1'b0, 4'd4, 1'b1, 1'b1, 1'b0},   // R3 below half
      {3'd1, 1'b0, 4'd5, 1'b0, 1'b0, 1'b1},   // R4 tie
      {3'd1, 1'b1, 4'd4, 1'b1, 1'b1, 1'b0},   // R4 below
      {3'd1, 1'b0, 4'd9, 1'b0, 1'b0, 1'b1},   // R4 high
      {3'd2, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1},   // R5 pos, sticky only
      {3'd2, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0},   // R5 pos, negative sign
      {3'd2, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0},   // R5 pos, exact
      {3'd3, 1'b1, 4'd0, 1'b1, 1'b0, 1'b1},   // R5 neg, sticky only
      {3'd3, 1'b0, 4'd7, 1'b0, 1'b0, 1'b0},   // R5 neg, positive sign
      {3'd3, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0},   // R5 neg, exact
      {3'd3, 1'b1, 4'd9, 1'b0, 1'b1, 1'b1},   // R5 neg, digit only
      {3'd4, 1'b0, 4'd9, 1'b1, 1'b1, 1'b0},   // R6 toward zero
      {3'd4, 1'b1, 4'd5, 1'b0, 1'b1, 1'b0},   // R6 toward zero tie
      {3'd5, 1'b0, 4'd9, 1'b1, 1'b0, 1'b0},   // R6 unused code
      {3'd7, 1'b1, 4'd6, 1'b0, 1'b1, 1'b0},   // R6 unused code
      {3'd0, 1'b1, 4'd5, 1'b0, 1'b0, 1'b0}    // R3 tie, even, negative
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_sign = 1'b0, in_sticky = 1'b0;
   logic [3:0]    in_rdig = '0;
   logic [SW-1:0] in_quot = '0, in_quot_inc = '0, dvd_sig = '0, dvs_sig = '0;
   logic [2:0]    in_mode = '0;
   logic dvd_zero = 0, dvd_inf = 0, dvd_qnan = 0, dvd_snan = 0;
   logic dvs_zero = 0, dvs_inf = 0, dvs_qnan = 0, dvs_snan = 0;
   logic in_ovf = 0, in_unf = 0;
   logic [SW-1:0] steer_dvd, steer_dvs, out_sig;
   logic out_valid, f_invalid, f_divzero, f_overflow, f_underflow, f_inexact, f_infinity;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dfr_div_round #(.NDIG(NDIG)) i_dfr_div_round (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_class();
      {dvd_zero, dvd_inf, dvd_qnan, dvd_snan} = '0;
      {dvs_zero, dvs_inf, dvs_qnan, dvs_snan} = '0;
      in_ovf = 0; in_unf = 0;
   endtask

   // one accepted input, then sample one cycle later on the falling edge
   task automatic fire();
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic flags_chk(input string req, input logic [5:0] exp);
      check(req, {f_invalid, f_divzero, f_overflow, f_underflow, f_inexact, f_infinity}, exp);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 valid in reset", out_valid, 0);
      check("R1 sig in reset", out_sig, 0);
      flags_chk("R1 flags in reset", 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after release", out_valid, 0);
      flags_chk("R1 flags after release", 6'b0);

      for (int i = 0; i < NV; i++) begin
         logic [SW-1:0] q, qi;
         q  = VEC[i][1] ? 16'h1235 : 16'h1234;
         qi = VEC[i][1] ? 16'h1236 : 16'h1235;
         in_mode = VEC[i][10:8]; in_sign = VEC[i][7];
         in_rdig = VEC[i][6:3];  in_sticky = VEC[i][2];
         in_quot = q; in_quot_inc = qi;
         fire();
         check($sformatf("R3-R6 vector %0d result", i), out_sig, VEC[i][0] ? qi : q);
         check($sformatf("R2 vector %0d valid", i), out_valid, 1);
         check($sformatf("R7 vector %0d inexact", i), f_inexact,
               (VEC[i][6:3] != 0) || VEC[i][2]);
         @(negedge clk);
      end

      // R2 hold: change inputs with in_valid low
      in_mode = 3'd1; in_rdig = 4'd9; in_quot = 16'h4444; in_quot_inc = 16'h4445;
      dvd_qnan = 1;
      @(negedge clk); @(negedge clk);
      check("R2 hold valid", out_valid, 0);
      check("R2 hold sig", out_sig, 16'h1234);
      flags_chk("R2 hold flags", 6'b000010);
      clear_class();
      in_rdig = 4'd0; in_sticky = 0;

      // order: invalid divzero overflow underflow inexact infinity
      dvs_zero = 1; fire();
      flags_chk("R8 R10 finite by zero", 6'b010001);
      clear_class(); dvd_zero = 1; dvs_zero = 1; fire();
      flags_chk("R9 zero by zero", 6'b100000);
      clear_class(); dvd_inf = 1; dvs_inf = 1; fire();
      flags_chk("R9 inf by inf", 6'b100000);
      clear_class(); dvd_inf = 1; fire();
      flags_chk("R10 inf by finite", 6'b000001);
      clear_class(); dvd_inf = 1; dvs_zero = 1; fire();
      flags_chk("R8 R10 inf by zero", 6'b000001);
      clear_class(); dvd_snan = 1; dvs_zero = 1; fire();
      flags_chk("R9 R8 snan by zero", 6'b100000);
      clear_class(); dvs_qnan = 1; fire();
      flags_chk("R9 qnan divisor", 6'b100000);
      clear_class(); in_ovf = 1; fire();
      flags_chk("R11 R10 overflow", 6'b001001);
      clear_class(); in_unf = 1; in_sticky = 1; fire();
      flags_chk("R11 R7 underflow inexact", 6'b000110);
      clear_class(); in_sticky = 0;

      // R12 R13 operand steering (combinational)
      dvd_sig = 16'h9871; dvs_sig = 16'h5432;
      #1;
      check("R12 pass dividend", steer_dvd, 16'h9871);
      check("R12 pass divisor", steer_dvs, 16'h5432);
      dvd_qnan = 1; #1;
      check("R12 dividend nan kept", steer_dvd, 16'h9871);
      check("R12 divisor forced to one", steer_dvs, 16'h0001);
      clear_class(); dvs_snan = 1; #1;
      check("R12 divisor nan forwarded", steer_dvd, 16'h5432);
      check("R12 divisor one on divisor nan", steer_dvs, 16'h0001);
      dvd_qnan = 1; #1;
      check("R13 both nan picks dividend", steer_dvd, 16'h9871);
      clear_class();

      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule